// File: doc/BRIEF.md
# Event State Buffer Page Decoder

This block turns loads and stores aimed at an event state buffer window into updates of 2-bit pending/queued (PQ) state. Each descriptor entry owns two neighbouring pages. The even page of the pair holds the notification PQ pair and the odd page holds the escalation PQ pair. The low twelve address bits select the operation: trigger, end-of-interrupt, read, set-PQ or inject.

One request is accepted per cycle. In the request cycle the block reads the selected PQ pair through a combinational storage port, computes the new state and drives the write-back at once, so the next request already sees the new state. One cycle later it returns the response (acknowledge, error flag, load data) and, when the operation asks for it, a one-cycle notify pulse that carries the entry index and the page parity. The page size is a parameter: shifts of 12 (4 KB) and 16 (64 KB) are legal.

PQ encoding: bit 1 is P (pending), bit 0 is Q (queued).

Top module: `esb_page_decoder`

## Requirements
- R1: The entry index is `bus_addr >> (PAGE_SHIFT+1)`. Bit `PAGE_SHIFT` selects the notification pair (0) or the escalation pair (1). The operation is decoded from `bus_addr[11:0]`. State in one pair never changes through an access to another pair or another entry.
- R2: Every request is acknowledged on `bus_ack` exactly one cycle later, and `bus_ack` is never high without a request in the cycle before. Stores return zero data. After reset no acknowledge and no notify is seen.
- R3: A load at offsets 0x000–0x7FF performs end-of-interrupt: 00→00, 10→00, 01→01, 11→10. The 11 case raises a notify. The load returns 1 when a notify happens and 0 otherwise.
- R4: A load at offsets 0x800–0xBFF returns the current PQ in data bits [1:0] and leaves the state unchanged.
- R5: A load at offsets 0xC00–0xFFF sets PQ to `bus_addr[9:8]` and returns the old PQ.
- R6: A store at offsets 0x000–0x3FF is a trigger: 00→10 with a notify, 10→11, 11→11, 01→01.
- R7: A store at offsets 0x400–0x7FF performs end-of-interrupt with the R3 transitions and the same notify.
- R8: A store at offsets 0x800–0xBFF on an even page injects a notify and leaves PQ unchanged. The same store on an odd page is rejected with `bus_err` and gives no notify.
- R9: A store at offsets 0xC00–0xFFF, or any access whose index is at least `NUM_ENTRIES`, sets `bus_err`, changes no state and gives no notify. A load that errs returns all ones.
- R10: The PQ write-back strobe is raised only in a request cycle, only without error, and only when the new PQ differs from the stored one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 for a store, 0 for a load |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_ack | output | 1 | Response valid, one cycle after the request |
| bus_err | output | 1 | Access rejected |
| bus_rdata | output | DATA_W | Load data |
| pq_rd_idx | output | IDX_W | Storage read index |
| pq_rd_esc | output | 1 | Storage read pair select (1 = escalation) |
| pq_rd_val | input | 2 | Stored PQ, combinational from the read address |
| pq_wr_en | output | 1 | Storage write strobe |
| pq_wr_idx | output | IDX_W | Storage write index |
| pq_wr_esc | output | 1 | Storage write pair select |
| pq_wr_val | output | 2 | New PQ value |
| notify_o | output | 1 | Notify pulse |
| notify_idx | output | IDX_W | Entry index of the notify |
| notify_esc | output | 1 | Pair of the notify (1 = escalation) |

## Verification
On every cycle the assertions check the response timing, that a write-back appears only with a request and always changes the value, that no error response carries a notify, that an erroring load returns all ones, and that a read-window load never writes. The per-operation transition tables, the returned values of end-of-interrupt and set-PQ, the even/odd inject rule and the isolation between pairs and entries depend on the stored state. Only the bench's scenarios show them: a reference model predicts every response and the final contents of the storage.

// File: rtl/esb_page_decoder.sv
module esb_page_decoder #(
  parameter int ADDR_W      = 24,
  parameter int PAGE_SHIFT  = 12,
  parameter int NUM_ENTRIES = 16,
  parameter int DATA_W      = 64,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              bus_ack,
  output logic              bus_err,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [IDX_W-1:0]  pq_rd_idx,
  output logic              pq_rd_esc,
  input  logic [1:0]        pq_rd_val,
  output logic              pq_wr_en,
  output logic [IDX_W-1:0]  pq_wr_idx,
  output logic              pq_wr_esc,
  output logic [1:0]        pq_wr_val,
  output logic              notify_o,
  output logic [IDX_W-1:0]  notify_idx,
  output logic              notify_esc
);
  localparam int FULL_W = ADDR_W - PAGE_SHIFT - 1;
  localparam logic [31:0] NUM_U = NUM_ENTRIES;

  if (PAGE_SHIFT != 12 && PAGE_SHIFT != 16) begin : g_bad_shift
    $error("page shift must be 12 or 16");
  end
  if (NUM_ENTRIES < 1) begin : g_bad_count
    $error("entry count must be nonzero");
  end
  if (FULL_W < IDX_W || FULL_W > 32) begin : g_bad_addr
    $error("address width does not fit the entry count");
  end

  logic [FULL_W-1:0] full_idx;
  logic [11:0]       off;
  logic              esc, idx_ok;
  logic [IDX_W-1:0]  idx;

  assign full_idx = bus_addr[ADDR_W-1:PAGE_SHIFT+1];
  assign esc      = bus_addr[PAGE_SHIFT];
  assign off      = bus_addr[11:0];
  assign idx      = full_idx[IDX_W-1:0];
  assign idx_ok   = 32'(full_idx) < NUM_U;

  function automatic logic [2:0] trig_step(input logic [1:0] pq);
    case (pq)
      2'b00:   trig_step = {1'b1, 2'b10};
      2'b01:   trig_step = {1'b0, 2'b01};
      default: trig_step = {1'b0, 2'b11};
    endcase
  endfunction

  function automatic logic [2:0] eoi_step(input logic [1:0] pq);
    case (pq)
      2'b11:   eoi_step = {1'b1, 2'b10};
      2'b01:   eoi_step = {1'b0, 2'b01};
      default: eoi_step = {1'b0, 2'b00};
    endcase
  endfunction

  logic [1:0] new_pq, ret_pq;
  logic       fire, fault;

  always_comb begin
    new_pq = pq_rd_val;
    ret_pq = 2'b00;
    fire   = 1'b0;
    fault  = 1'b0;
    if (!idx_ok) begin
      fault = 1'b1;
    end else if (!bus_we) begin
      case (off[11:10])
        2'b00, 2'b01: begin
          {fire, new_pq} = eoi_step(pq_rd_val);
          ret_pq = {1'b0, fire};
        end
        2'b10:   ret_pq = pq_rd_val;
        default: begin
          new_pq = off[9:8];
          ret_pq = pq_rd_val;
        end
      endcase
    end else begin
      case (off[11:10])
        2'b00: {fire, new_pq} = trig_step(pq_rd_val);
        2'b01: {fire, new_pq} = eoi_step(pq_rd_val);
        2'b10: begin
          if (esc) fault = 1'b1;
          else     fire  = 1'b1;
        end
        default: fault = 1'b1;
      endcase
    end
  end

  assign pq_rd_idx = idx;
  assign pq_rd_esc = esc;
  assign pq_wr_idx = idx;
  assign pq_wr_esc = esc;
  assign pq_wr_val = new_pq;
  assign pq_wr_en  = bus_req && !fault && (new_pq != pq_rd_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ack    <= 1'b0;
      bus_err    <= 1'b0;
      bus_rdata  <= '0;
      notify_o   <= 1'b0;
      notify_idx <= '0;
      notify_esc <= 1'b0;
    end else begin
      bus_ack  <= bus_req;
      bus_err  <= bus_req && fault;
      notify_o <= bus_req && fire && !fault;
      if (bus_req) begin
        if (bus_we)     bus_rdata <= '0;
        else if (fault) bus_rdata <= '1;
        else            bus_rdata <= DATA_W'(ret_pq);
        notify_idx <= idx;
        notify_esc <= esc;
      end
    end
  end

  a_r2_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_ack);
  a_r2_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !bus_ack);
  a_r10_wb_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    pq_wr_en |-> bus_req);
  a_r10_wb_changes: assert property (@(posedge clk) disable iff (!rst_n)
    pq_wr_en |-> (pq_wr_val != pq_rd_val));
  a_r9_err_no_notify: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && bus_err) |-> !notify_o);
  a_r9_err_load_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && bus_err && !$past(bus_we)) |-> (&bus_rdata));
  a_r4_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_addr[11:10] == 2'b10) |-> !pq_wr_en);
  a_r2_notify_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    notify_o |-> bus_ack);
endmodule

// File: tb/esb_page_decoder_tb_top.sv
module esb_page_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int PS     = 12;
  localparam int NENT   = 16;
  localparam int DW     = 64;
  localparam int IW     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_ack, bus_err, notify_o, notify_esc, pq_rd_esc, pq_wr_en, pq_wr_esc;
  logic [DW-1:0] bus_rdata;
  logic [IW-1:0] pq_rd_idx, pq_wr_idx, notify_idx;
  logic [1:0] pq_rd_val, pq_wr_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  esb_page_decoder #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PS), .NUM_ENTRIES(NENT), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .pq_rd_idx(pq_rd_idx), .pq_rd_esc(pq_rd_esc), .pq_rd_val(pq_rd_val),
    .pq_wr_en(pq_wr_en), .pq_wr_idx(pq_wr_idx), .pq_wr_esc(pq_wr_esc), .pq_wr_val(pq_wr_val),
    .notify_o(notify_o), .notify_idx(notify_idx), .notify_esc(notify_esc));

  logic [1:0] mem [2*NENT];
  int writes = 0;
  initial for (int i = 0; i < 2*NENT; i++) mem[i] = 2'b00;
  assign pq_rd_val = mem[{pq_rd_idx, pq_rd_esc}];
  always @(posedge clk) if (pq_wr_en) begin
    mem[{pq_wr_idx, pq_wr_esc}] <= pq_wr_val;
    writes <= writes + 1;
  end

  typedef struct {
    logic [DW-1:0] rd;
    bit err;
    bit nt;
    int nidx;
    bit nesc;
    string tag;
  } exp_t;
  exp_t q[$];

  bit [1:0] ref_pq [2*NENT];
  int exp_writes = 0;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  initial for (int i = 0; i < 2*NENT; i++) ref_pq[i] = 2'b00;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic op(input bit we, input int idx, input bit esc, input int off, input string tag);
    exp_t e;
    bit [1:0] old, nw;
    bit nt, err;
    int slot;
    slot = idx * 2 + int'(esc);
    old = (idx < NENT) ? ref_pq[slot] : 2'b00;
    nw = old; nt = 0; err = 0;
    e.rd = '0;
    if (idx >= NENT) err = 1;
    else if (!we) begin
      if (off < 'h800) begin
        nt = (old == 2'b11);
        nw = (old == 2'b11) ? 2'b10 : (old == 2'b01) ? 2'b01 : 2'b00;
        e.rd = DW'(nt);
      end else if (off < 'hC00) e.rd = DW'(old);
      else begin
        nw = 2'(off >> 8);
        e.rd = DW'(old);
      end
    end else begin
      if (off < 'h400) begin
        nt = (old == 2'b00);
        nw = (old == 2'b00) ? 2'b10 : (old == 2'b01) ? 2'b01 : 2'b11;
      end else if (off < 'h800) begin
        nt = (old == 2'b11);
        nw = (old == 2'b11) ? 2'b10 : (old == 2'b01) ? 2'b01 : 2'b00;
      end else if (off < 'hC00) begin
        if (esc) err = 1; else nt = 1;
      end else err = 1;
    end
    if (err) begin
      nt = 0; nw = old;
      e.rd = we ? '0 : '1;
    end
    if (!err && nw != old) begin
      ref_pq[slot] = nw;
      exp_writes++;
    end
    e.err = err; e.nt = nt; e.nidx = idx; e.nesc = esc; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    bus_req  = 1'b1;
    bus_we   = we;
    bus_addr = ADDR_W'((idx << (PS + 1)) | (int'(esc) << PS) | off);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_req = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (bus_ack) begin
        if (q.size() == 0) check(0, "R2 unexpected ack", "ack", "none");
        else begin
          exp_t e;
          bit ok;
          e = q.pop_front();
          ok = (bus_rdata == e.rd) && (bus_err == e.err) && (notify_o == e.nt);
          if (e.nt) ok = ok && (int'(notify_idx) == e.nidx) && (notify_esc == e.nesc);
          check(ok, e.tag,
                $sformatf("rd=%0h err=%0b nt=%0b idx=%0d esc=%0b", bus_rdata, bus_err, notify_o, notify_idx, notify_esc),
                $sformatf("rd=%0h err=%0b nt=%0b idx=%0d esc=%0b", e.rd, e.err, e.nt, e.nidx, e.nesc));
        end
      end else if (notify_o) check(0, "R2 notify without ack", "1", "0");
    end
  end

  task automatic finish_test();
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_test();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!bus_ack && !notify_o, "R2 reset state", $sformatf("%0b%0b", bus_ack, notify_o), "00");

    op(0, 3, 0, 'h800, "R4 read initial 00");
    op(1, 3, 0, 'h010, "R6 trigger 00->10 notify");
    op(1, 3, 0, 'h3FC, "R6 trigger 10->11");
    op(1, 3, 0, 'h000, "R6 R10 trigger 11 stays, no write");
    op(0, 3, 0, 'h100, "R3 load eoi 11->10 returns 1");
    op(0, 3, 0, 'h7F8, "R3 load eoi 10->00 returns 0");
    op(0, 3, 1, 'hD00, "R5 set 01 on escalation returns 00");
    op(1, 3, 1, 'h000, "R6 trigger 01 stays 01");
    op(0, 3, 1, 'h800, "R1 R4 escalation pair reads 01");
    op(0, 3, 0, 'hBF0, "R1 notification pair still 00");
    op(0, 3, 1, 'h200, "R3 load eoi on 01 stays, returns 0");
    op(0, 5, 0, 'hF00, "R5 set 11 returns 00");
    op(1, 5, 0, 'h400, "R7 store eoi 11->10 notify");
    op(1, 5, 0, 'h7FC, "R7 store eoi 10->00");
    op(0, 5, 0, 'hEFF, "R5 set 10 returns 00");
    op(0, 5, 0, 'hC80, "R5 set 00 returns 10");
    op(1, 7, 0, 'h800, "R8 inject even page notifies");
    op(1, 7, 1, 'h800, "R8 inject odd page rejected");
    op(0, 7, 0, 'h800, "R8 inject leaves PQ 00");
    op(1, 9, 0, 'hC00, "R9 store at set window errs");
    op(0, 9, 0, 'h800, "R9 state unchanged after error");
    op(0, 16, 0, 'h800, "R9 index out of range load all ones");
    op(1, 17, 1, 'h000, "R9 index out of range store errs");
    op(1, 15, 1, 'h000, "R1 top entry escalation trigger");
    op(0, 15, 1, 'hE00, "R5 top entry set 10 returns 10");
    op(1, 15, 1, 'h000, "R6 top entry trigger 10->11");
    idle(4);

    check(q.size() == 0, "R2 all responses seen", $sformatf("%0d", q.size()), "0");
    check(writes == exp_writes, "R10 write-back count", $sformatf("%0d", writes), $sformatf("%0d", exp_writes));
    for (int i = 0; i < 2*NENT; i++)
      check(mem[i] == ref_pq[i], "R1 final storage", $sformatf("slot%0d=%0b", i, mem[i]), $sformatf("%0b", ref_pq[i]));
    finish_test();
  end
endmodule